// File: doc/BRIEF.md
# Costas Loop Carrier Phase Tracker

This block sits at the end of a digital receive chain and removes the residual carrier phase and frequency offset from a stream of complex baseband samples. Each accepted sample (signed I and Q) is de-rotated by the current phase estimate in a pipelined CORDIC rotator. A phase error is taken from that de-rotated result, and a second-order loop is updated. The loop has a frequency integrator and a 32-bit phase accumulator in which the full count is one turn. The de-rotated sample is then presented at the output.

By default the error detector uses only sign tests, negation and one subtraction: `err = s(I)*Q - s(Q)*I`, where `s(x)` is +1 for x > 0 and -1 otherwise. A build parameter `ERR_IQ` swaps in the product term `(I*Q) >>> (W-1)`, which costs one multiplier. Both loop gains are arithmetic right shifts that software writes at run time.

A two-state controller runs the block. In `ST_IDLE` the block is ready for a sample. The transition `ST_IDLE -> ST_BUSY` is taken when a sample is accepted. In `ST_BUSY` the block waits for that sample to leave the rotator. The transition `ST_BUSY -> ST_IDLE` is taken on the cycle the rotated sample arrives. On that edge the output registers and the loop are updated together, so every accepted sample is rotated by a phase that already includes the error of the sample before it.

Top module: `costas_tracker`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the phase and frequency registers, drops `out_valid`, returns to `ST_IDLE` (`in_ready` high), and sets the gain shifts to alpha = 7 and beta = 8.
- R2: The phase error is computed from the de-rotated output sample as `err = (I > 0 ? Q : -Q) - (Q > 0 ? I : -I)`. A component equal to zero counts as negative.
- R3: For each output sample, with `e = err * 2^16`: first `freq <= freq + (e >>> beta)`, then `phase <= phase + freq_new + (e >>> alpha)`. All values are taken modulo 2^32. `phase_est` shows the new phase in the same cycle that `out_valid` is high.
- R4: A cycle with `cfg_we` high loads `cfg_alpha` and `cfg_beta` (5-bit shift counts). Every loop update after that edge uses the new values.
- R5: `out_i + j*out_q` equals `(in_i + j*in_q) * exp(-j*2*pi*P/2^32)` to within 16 LSB, where P is `phase_est` at the accept edge. The result saturates to the signed 16-bit range.
- R6: `in_ready` is high only in `ST_IDLE`. A sample is accepted on an edge where `in_valid` and `in_ready` are both high. An `in_valid` asserted while `in_ready` is low is ignored: it produces no output and no loop update.
- R7: `out_valid` is a one-cycle pulse. It appears STAGES+2 clock edges after the accept edge, and `in_ready` is high again in that same cycle.
- R8: `phase_est` changes only in cycles where `out_valid` is high, or through reset.
- R9: With alpha = 4 and beta = 10 and a QPSK input that has a constant phase and frequency offset, the loop settles. After settling, `||out_i| - |out_q||` stays below 1200, and the mapping from transmitted to received quadrant stays fixed (the loop has a 90-degree ambiguity).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_i | input | W | Input in-phase component, signed |
| in_q | input | W | Input quadrature component, signed |
| in_ready | output | 1 | High when a sample can be accepted |
| out_valid | output | 1 | One-cycle pulse marking a de-rotated sample |
| out_i | output | W | De-rotated in-phase component, signed |
| out_q | output | W | De-rotated quadrature component, signed |
| cfg_we | input | 1 | Write strobe for the gain shifts |
| cfg_alpha | input | 5 | Proportional gain shift count |
| cfg_beta | input | 5 | Integral gain shift count |
| phase_est | output | 32 | Current phase estimate, full count = one turn |

## Verification
The bench counts every edge after the accept edge and requires the de-rotated sample to appear after exactly STAGES+2 of them. It reads `out_i`, `out_q` and `phase_est` at the falling edge that follows, because the output registers and the loop registers load on the same rising edge. From the observed output, the bench model computes the error and the new frequency and phase bit-exactly. It checks the rotation itself against a floating-point reference built from the phase the model held when the sample was accepted. One cycle later it confirms that the pulse has ended and that the phase has held, so any input stray while the block was busy would be seen.

// File: rtl/costas_pkg.sv
package costas_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_BUSY
    } trk_state_e;

    localparam int PHASE_W = 32;
    localparam int SHIFT_W = 5;

    // Rotation angle of CORDIC step idx: atan(2^-idx), full turn = 2^32
    function automatic logic [PHASE_W-1:0] step_angle(input int idx);
        case (idx)
            0:  return 32'd536870912;
            1:  return 32'd316933406;
            2:  return 32'd167458907;
            3:  return 32'd85004756;
            4:  return 32'd42667331;
            5:  return 32'd21354465;
            6:  return 32'd10679838;
            7:  return 32'd5340245;
            8:  return 32'd2670163;
            9:  return 32'd1335087;
            10: return 32'd667544;
            11: return 32'd333772;
            12: return 32'd166886;
            13: return 32'd83443;
            14: return 32'd41722;
            15: return 32'd20861;
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/costas_cordic.sv
module costas_cordic #(
    parameter int W      = 16,
    parameter int STAGES = 14,
    parameter int GUARD  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       vld_in,
    input  logic signed [W-1:0]        i_in,
    input  logic signed [W-1:0]        q_in,
    input  logic [costas_pkg::PHASE_W-1:0] ang_in,
    output logic                       vld_out,
    output logic signed [W-1:0]        i_out,
    output logic signed [W-1:0]        q_out
);
    import costas_pkg::*;

    localparam int IW = W + 3 + GUARD;
    localparam logic signed [IW-1:0] SAT_HI = IW'((1 << (W-1)) - 1);
    localparam logic signed [IW-1:0] SAT_LO = -SAT_HI - IW'(1);
    localparam logic signed [IW-1:0] HALF   = IW'(1 << (GUARD-1));

    logic signed [IW-1:0]      xe, ye, px, py;
    logic signed [PHASE_W-1:0] pz;
    logic signed [IW-1:0]      xs [0:STAGES];
    logic signed [IW-1:0]      ys [0:STAGES];
    logic signed [PHASE_W-1:0] zs [0:STAGES];
    logic [STAGES:0]           vld_sr;

    // Quadrant pre-rotation: the residual angle lands in [0, quarter turn)
    always_comb begin
        xe = IW'(i_in) <<< GUARD;
        ye = IW'(q_in) <<< GUARD;
        pz = {2'b00, ang_in[PHASE_W-3:0]};
        unique case (ang_in[PHASE_W-1:PHASE_W-2])
            2'b00: begin px = xe;  py = ye;  end
            2'b01: begin px = ye;  py = -xe; end
            2'b10: begin px = -xe; py = -ye; end
            2'b11: begin px = -ye; py = xe;  end
        endcase
    end

    // Constant gain compensation (about 0.6073) by shift-add, round, saturate
    function automatic logic signed [W-1:0] descale(input logic signed [IW-1:0] v);
        logic signed [IW-1:0] s;
        s = (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9) - (v >>> 13);
        s = (s + HALF) >>> GUARD;
        if (s > SAT_HI)      return W'(SAT_HI);
        else if (s < SAT_LO) return W'(SAT_LO);
        else                 return W'(s);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) vld_sr <= '0;
        else     vld_sr <= {vld_sr[STAGES-1:0], vld_in};
    end

    always_ff @(posedge clk) begin
        xs[0] <= px;
        ys[0] <= py;
        zs[0] <= pz;
        for (int k = 0; k < STAGES; k++) begin
            if (!zs[k][PHASE_W-1]) begin
                xs[k+1] <= xs[k] + (ys[k] >>> k);
                ys[k+1] <= ys[k] - (xs[k] >>> k);
                zs[k+1] <= zs[k] - $signed(step_angle(k));
            end else begin
                xs[k+1] <= xs[k] - (ys[k] >>> k);
                ys[k+1] <= ys[k] + (xs[k] >>> k);
                zs[k+1] <= zs[k] + $signed(step_angle(k));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vld_out <= 1'b0;
        else     vld_out <= vld_sr[STAGES];
        i_out <= descale(xs[STAGES]);
        q_out <= descale(ys[STAGES]);
    end

endmodule

// File: rtl/costas_err_det.sv
module costas_err_det #(
    parameter int W      = 16,
    parameter int EW     = W + 2,
    parameter bit ERR_IQ = 1'b0
) (
    input  logic signed [W-1:0]  i_s,
    input  logic signed [W-1:0]  q_s,
    output logic signed [EW-1:0] err
);
    generate
        if (ERR_IQ) begin : g_product
            logic signed [2*W-1:0] prod;
            always_comb begin
                prod = i_s * q_s;
                err  = EW'(prod >>> (W-1));
            end
        end else begin : g_sign
            logic signed [EW-1:0] ie, qe, term_a, term_b;
            always_comb begin
                ie     = EW'(i_s);
                qe     = EW'(q_s);
                term_a = (i_s > 0) ? qe : -qe;
                term_b = (q_s > 0) ? ie : -ie;
                err    = term_a - term_b;
            end
            // R2: the sign detector never exceeds |I| + |Q|
            always_comb begin
                a_r2_err_bound: assert ((err < 0 ? -err : err) <=
                    ((ie < 0 ? -ie : ie) + (qe < 0 ? -qe : qe)));
            end
        end
    endgenerate

endmodule

// File: rtl/costas_loop_filter.sv
module costas_loop_filter #(
    parameter int EW        = 18,
    parameter int ERR_LSH   = 16,
    parameter int DEF_ALPHA = 7,
    parameter int DEF_BETA  = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [costas_pkg::SHIFT_W-1:0]    cfg_alpha,
    input  logic [costas_pkg::SHIFT_W-1:0]    cfg_beta,
    input  logic                              upd,
    input  logic signed [EW-1:0]              err,
    output logic [costas_pkg::PHASE_W-1:0]    phase_out
);
    import costas_pkg::*;

    localparam int XW = EW + ERR_LSH;

    logic [SHIFT_W-1:0]   alpha_q, beta_q;
    logic [PHASE_W-1:0]   freq_q, phase_q, freq_n, phase_n;
    logic signed [XW-1:0] ex;

    always_comb begin
        ex      = XW'(err) <<< ERR_LSH;
        freq_n  = freq_q + PHASE_W'(ex >>> beta_q);
        phase_n = phase_q + freq_n + PHASE_W'(ex >>> alpha_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alpha_q <= SHIFT_W'(DEF_ALPHA);
            beta_q  <= SHIFT_W'(DEF_BETA);
            freq_q  <= '0;
            phase_q <= '0;
        end else begin
            if (cfg_we) begin
                alpha_q <= cfg_alpha;
                beta_q  <= cfg_beta;
            end
            if (upd) begin
                freq_q  <= freq_n;
                phase_q <= phase_n;
            end
        end
    end

    assign phase_out = phase_q;

    // R4: a shift write takes effect on the following edge
    a_r4_cfg_load: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (alpha_q == $past(cfg_alpha) && beta_q == $past(cfg_beta)));

endmodule

// File: rtl/costas_tracker.sv
module costas_tracker #(
    parameter int W         = 16,
    parameter int STAGES    = 14,
    parameter bit ERR_IQ    = 1'b0,
    parameter int ERR_LSH   = 16,
    parameter int DEF_ALPHA = 7,
    parameter int DEF_BETA  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_i,
    input  logic signed [W-1:0]  in_q,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic signed [W-1:0]  out_i,
    output logic signed [W-1:0]  out_q,
    input  logic                 cfg_we,
    input  logic [4:0]           cfg_alpha,
    input  logic [4:0]           cfg_beta,
    output logic [31:0]          phase_est
);
    import costas_pkg::*;

    localparam int LAT = STAGES + 2;
    localparam int EW  = W + 2;
    localparam int CW  = $clog2(LAT + 1);

    trk_state_e          state_q, state_n;
    logic                accept, upd, rot_vld;
    logic signed [W-1:0] rot_i, rot_q;
    logic signed [EW-1:0] err;
    logic [CW-1:0]       busy_cnt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_n = ST_BUSY;
            ST_BUSY: if (rot_vld)  state_n = ST_IDLE;
        endcase
    end

    // State-decoded controls
    always_comb begin
        in_ready = 1'b0;
        upd      = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready = 1'b1;
            ST_BUSY: upd      = rot_vld;
        endcase
        accept = in_valid && in_ready;
    end

    costas_cordic #(.W(W), .STAGES(STAGES), .GUARD(3)) u_rot (
        .clk    (clk),
        .rst    (rst),
        .vld_in (accept),
        .i_in   (in_i),
        .q_in   (in_q),
        .ang_in (phase_est),
        .vld_out(rot_vld),
        .i_out  (rot_i),
        .q_out  (rot_q)
    );

    costas_err_det #(.W(W), .EW(EW), .ERR_IQ(ERR_IQ)) u_det (
        .i_s(rot_i),
        .q_s(rot_q),
        .err(err)
    );

    costas_loop_filter #(
        .EW(EW), .ERR_LSH(ERR_LSH), .DEF_ALPHA(DEF_ALPHA), .DEF_BETA(DEF_BETA)
    ) u_loop (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_alpha(cfg_alpha),
        .cfg_beta (cfg_beta),
        .upd      (upd),
        .err      (err),
        .phase_out(phase_est)
    );

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= upd;
            if (upd) begin
                out_i <= rot_i;
                out_q <= rot_q;
            end
        end
    end

    // Edges spent in ST_BUSY, used to check the pipeline latency
    always_ff @(posedge clk) begin
        if (rst || accept)          busy_cnt <= '0;
        else if (state_q == ST_BUSY) busy_cnt <= busy_cnt + CW'(1);
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase_est == '0 && !out_valid && in_ready));

    a_r6_ready_with_output: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    a_r7_rotator_latency: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY && rot_vld) |-> busy_cnt == CW'(LAT - 1));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r8_phase_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && phase_est != $past(phase_est)) |-> out_valid);

endmodule

// File: tb/costas_tracker_bench.sv
`timescale 1ns/1ps
module costas_tracker_bench;

    localparam int    STAGES = 14;
    localparam int    LAT    = STAGES + 2;
    localparam real   TWO_PI = 6.283185307179586;
    localparam real   TURN   = 4294967296.0;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic               in_ready, out_valid;
    logic signed [15:0] out_i, out_q;
    logic               cfg_we = 1'b0;
    logic [4:0]         cfg_alpha = '0, cfg_beta = '0;
    logic [31:0]        phase_est;

    int          n_chk = 0, n_bad = 0;
    logic [31:0] ph_m = '0, fr_m = '0;
    int          alpha_m = 7, beta_m = 8;

    always #10 clk = ~clk;

    costas_tracker #(.STAGES(STAGES)) u_costas_tracker (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .in_ready(in_ready), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
        .cfg_we(cfg_we), .cfg_alpha(cfg_alpha), .cfg_beta(cfg_beta),
        .phase_est(phase_est)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint det(input int oi, input int oq);
        return longint'((oi > 0) ? oq : -oq) - longint'((oq > 0) ? oi : -oi);
    endfunction

    function automatic logic [31:0] scaled(input longint e, input int sh);
        longint x;
        x = (e <<< 16) >>> sh;
        return x[31:0];
    endfunction

    function automatic real sat16(input real v);
        if (v > 32767.0)  return 32767.0;
        if (v < -32768.0) return -32768.0;
        return v;
    endfunction

    function automatic real rabs(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    function automatic int quad(input int a, input int b);
        if (a > 0) return (b > 0) ? 0 : 3;
        return (b > 0) ? 1 : 2;
    endfunction

    // One sample through the block; poke drives in_valid while busy (R6)
    task automatic send(input int si, input int sq, input bit poke,
                        output int oi, output int oq);
        real th, ei, eq;
        int  cnt;
        logic [31:0] ph_hold;
        th = real'(ph_m) * TWO_PI / TURN;
        ei = sat16(si * $cos(th) + sq * $sin(th));
        eq = sat16(sq * $cos(th) - si * $sin(th));
        @(negedge clk);
        check(in_ready == 1'b1, "R6", "ready before accept", in_ready, 1);
        check(phase_est == ph_m, "R8", "phase held between samples", phase_est, ph_m);
        in_valid = 1'b1; in_i = 16'(si); in_q = 16'(sq);
        @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b0, "R6", "ready low while busy", in_ready, 0);
        cnt = 0;
        in_valid = poke; in_i = 16'sh1234; in_q = -16'sh2345;
        while (!out_valid && cnt < 100) begin
            @(posedge clk);
            @(negedge clk);
            cnt++;
            in_valid = poke && (cnt < LAT - 1);
        end
        in_valid = 1'b0;
        check(cnt == LAT, "R7", "output latency", cnt, LAT);
        oi = int'(out_i); oq = int'(out_q);
        check(rabs(real'(oi) - ei) <= 16.0, "R5", "rotated I", oi, $rtoi(ei));
        check(rabs(real'(oq) - eq) <= 16.0, "R5", "rotated Q", oq, $rtoi(eq));
        fr_m = fr_m + scaled(det(oi, oq), beta_m);
        ph_m = ph_m + fr_m + scaled(det(oi, oq), alpha_m);
        check(phase_est == ph_m, "R2/R3", "loop phase update", phase_est, ph_m);
        ph_hold = phase_est;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R7", "single pulse", out_valid, 0);
        check(in_ready == 1'b1, "R6", "idle after output", in_ready, 1);
        check(phase_est == ph_hold, "R8", "phase stable after pulse", phase_est, ph_hold);
    endtask

    task automatic write_cfg(input int a, input int b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_alpha = 5'(a); cfg_beta = 5'(b);
        @(negedge clk);
        cfg_we = 1'b0;
        alpha_m = a; beta_m = b;
    endtask

    function automatic int rnd(input int span);
        return int'($urandom_range(2 * span)) - span;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int oi, oq, ref_rot, seed_dummy;
        seed_dummy = int'($urandom(32'd20240));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(phase_est == 32'd0, "R1", "phase after reset", phase_est, 0);

        // R2 directed: zero components count as negative; R1 default shifts in model
        send(1000, 0, 1'b0, oi, oq);
        send(0, 500, 1'b0, oi, oq);
        send(0, 0, 1'b0, oi, oq);
        send(-700, -700, 1'b0, oi, oq);
        send(32767, -32768, 1'b0, oi, oq);

        // R6: random samples, every third with in_valid held while busy
        for (int n = 0; n < 40; n++) send(rnd(20000), rnd(20000), (n % 3) == 0, oi, oq);

        // R4: new gains; R3: zero shifts force modulo wrap of the accumulators
        write_cfg(2, 3);
        for (int n = 0; n < 15; n++) send(rnd(20000), rnd(20000), 1'b0, oi, oq);
        write_cfg(0, 0);
        for (int n = 0; n < 10; n++) send(rnd(30000), rnd(30000), 1'b0, oi, oq);

        // R1: reset in mid-run restores zero phase and default shifts
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check(phase_est == 32'd0, "R1", "phase after mid-run reset", phase_est, 0);
        ph_m = '0; fr_m = '0; alpha_m = 7; beta_m = 8;
        for (int n = 0; n < 6; n++) send(rnd(20000), rnd(20000), 1'b0, oi, oq);

        // R9: QPSK tracking with phase and frequency offset
        write_cfg(4, 10);
        ref_rot = -1;
        for (int n = 0; n < 500; n++) begin
            int  sI, sQ, vi, vq, d;
            real th, xr, yr;
            sI = ($urandom_range(1) == 0) ? 1 : -1;
            sQ = ($urandom_range(1) == 0) ? 1 : -1;
            th = 0.9 + 0.004 * n;
            xr = 6000.0 * (sI * $cos(th) - sQ * $sin(th));
            yr = 6000.0 * (sI * $sin(th) + sQ * $cos(th));
            vi = $rtoi(xr + ((xr >= 0.0) ? 0.5 : -0.5));
            vq = $rtoi(yr + ((yr >= 0.0) ? 0.5 : -0.5));
            send(vi, vq, 1'b0, oi, oq);
            if (n >= 350) begin
                int ai, aq;
                ai = (oi < 0) ? -oi : oi;
                aq = (oq < 0) ? -oq : oq;
                check(((ai > aq) ? ai - aq : aq - ai) < 1200, "R9",
                      "locked |I|-|Q|", ai - aq, 0);
                d = (quad(oi, oq) - quad(sI, sQ) + 4) % 4;
                if (ref_rot < 0) ref_rot = d;
                check(d == ref_rot, "R9", "quadrant mapping", d, ref_rot);
            end
        end
        finish_run();
    end

endmodule